// File: doc/BRIEF.md
# Peak and negative-slope voltage terminator

This block decides when fast charging of a nickel battery should stop. It watches a stream of battery-voltage readings, each a 12-bit unsigned millivolt value from an ADC. A sample strobe opens a burst, and the block averages that burst into one sample. The burst length is a power of two, chosen so that the averaging window cancels mains ripple. The block keeps the highest in-window sample since the last history clear. It flags termination once a new sample has dropped far enough below that maximum.

Two detection modes exist. Peak mode (mode select 0) reacts to a small drop and averages 32 readings. Negative-delta mode (mode select 1) waits for a larger drop and averages 16 readings. A hold-off flag masks termination during the first part of the charge. A history-clear pulse discards the stored maximum and any burst in progress.

Readings enter on a valid/ready stream. `rd_ready` is high only while a burst is open, so readings offered outside a burst wait at the port and are not consumed. A reading transfers on any rising clock edge where `rd_valid` and `rd_ready` are both high. The source may drop `rd_valid` between readings for any number of cycles; the burst then waits.

Top module: `vdrop_term`

## Requirements
- R1: After reset `term`, `eval_done` and `rd_ready` are low, and no maximum is stored.
- R2: A `smp_start` pulse while no burst is open opens one: `rd_ready` is high from the following cycle. A `smp_start` while a burst is open is ignored and does not change the burst length.
- R3: The mode is latched when the burst opens. A burst takes 32 readings in mode 0 and 16 readings in mode 1, after which `rd_ready` is low from the cycle after the last transfer.
- R4: The sample is the sum of the burst readings shifted right by 5 (mode 0) or 4 (mode 1): the floor of the mean, with no rounding.
- R5: For every completed burst, `eval_done` is high for exactly one cycle, the second cycle after the edge that took the last reading. `term` has its updated value in that same cycle.
- R6: Only a sample strictly between 1000 mV and 2000 mV is used. A sample outside that window neither updates the stored maximum nor sets `term`, but still pulses `eval_done`.
- R7: The first in-window sample after reset or a clear only becomes the stored maximum and never sets `term`.
- R8: In mode 0, an in-window sample at least 3 mV below the stored maximum sets `term`; a drop of 2 mV does not.
- R9: In mode 1, an in-window sample at least 12 mV below the stored maximum sets `term`; a drop of 11 mV does not.
- R10: While `holdoff` is high at evaluation, `term` is not set, but a higher in-window sample still raises the stored maximum.
- R11: An in-window sample above the stored maximum replaces it. Once set, `term` stays high until `hist_clr` or reset.
- R12: `hist_clr` takes effect on the next edge. It drops `term`, forgets the maximum, closes any open burst (`rd_ready` low) and discards that burst's readings without an `eval_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_start | input | 1 | Opens an averaging burst |
| mode_sel | input | 1 | 0 = peak mode, 1 = negative-delta mode |
| holdoff | input | 1 | Masks termination while high |
| hist_clr | input | 1 | Clears history, `term` and any open burst |
| rd_valid | input | 1 | Reading stream valid |
| rd_ready | output | 1 | Reading stream ready (burst open) |
| rd_mv | input | 12 | Battery reading in mV |
| term | output | 1 | Sticky terminate flag |
| eval_done | output | 1 | One-cycle pulse per evaluated sample |

## Verification
The last reading of a burst is taken on an edge L. The sample is registered at L, and then evaluated at L+1, where `term` and `eval_done` are updated together. `eval_done` falls again after L+2. `rd_ready` rises one edge after the strobe and falls right after L. A clear acts on the next edge. Each bench task samples the outputs on the falling edge that follows the relevant rising edge, counted in this way, and it also checks that `eval_done` is low one cycle later.

// File: rtl/vdt_pkg.sv
package vdt_pkg;

  typedef enum logic {
    MODE_PEAK = 1'b0,
    MODE_NDV  = 1'b1
  } vdt_mode_e;

  function automatic int unsigned vdt_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vdt_burst_seq.sv
module vdt_burst_seq
  import vdt_pkg::*;
#(
  parameter int unsigned PEAK_LOG2 = 5,
  parameter int unsigned NDV_LOG2  = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      clr,
  input  vdt_mode_e mode_in,
  input  logic      rd_valid,
  output logic      rd_ready,
  output logic      take,
  output logic      take_last,
  output vdt_mode_e mode_q
);

  localparam int unsigned MAX_LOG2 = vdt_max(PEAK_LOG2, NDV_LOG2);
  localparam int unsigned CNT_W    = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;
  localparam logic [CNT_W-1:0] PEAK_LAST = CNT_W'((1 << PEAK_LOG2) - 1);
  localparam logic [CNT_W-1:0] NDV_LAST  = CNT_W'((1 << NDV_LOG2) - 1);

  logic             open_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;

  assign last_idx  = (mode_q == MODE_PEAK) ? PEAK_LAST : NDV_LAST;
  assign rd_ready  = open_q;
  assign take      = open_q && rd_valid;
  assign take_last = take && (cnt_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      mode_q <= MODE_PEAK;
    end else if (clr) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!open_q) begin
      if (start) begin
        open_q <= 1'b1;
        cnt_q  <= '0;
        mode_q <= mode_in;
      end
    end else if (take) begin
      if (take_last) begin
        open_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vdt_accum.sv
module vdt_accum
  import vdt_pkg::*;
#(
  parameter int unsigned RD_W      = 12,
  parameter int unsigned PEAK_LOG2 = 5,
  parameter int unsigned NDV_LOG2  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            take,
  input  logic            take_last,
  input  vdt_mode_e       mode_q,
  input  logic [RD_W-1:0] rd_mv,
  output logic            avg_vld,
  output logic [RD_W-1:0] avg_mv,
  output vdt_mode_e       avg_mode
);

  localparam int unsigned MAX_LOG2 = vdt_max(PEAK_LOG2, NDV_LOG2);
  localparam int unsigned ACC_W    = RD_W + MAX_LOG2;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum_nx;
  logic [RD_W-1:0]  mean_nx;

  assign sum_nx = acc_q + ACC_W'(rd_mv);

  generate
    if (PEAK_LOG2 == NDV_LOG2) begin : g_same_shift
      assign mean_nx = RD_W'(sum_nx >> PEAK_LOG2);
    end else begin : g_mode_shift
      assign mean_nx = (mode_q == MODE_PEAK) ? RD_W'(sum_nx >> PEAK_LOG2)
                                             : RD_W'(sum_nx >> NDV_LOG2);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      avg_vld  <= 1'b0;
      avg_mv   <= '0;
      avg_mode <= MODE_PEAK;
    end else if (clr) begin
      acc_q   <= '0;
      avg_vld <= 1'b0;
    end else begin
      avg_vld <= 1'b0;
      if (take) begin
        if (take_last) begin
          acc_q    <= '0;
          avg_vld  <= 1'b1;
          avg_mv   <= mean_nx;
          avg_mode <= mode_q;
        end else begin
          acc_q <= sum_nx;
        end
      end
    end
  end

endmodule

// File: rtl/vdt_drop_eval.sv
module vdt_drop_eval
  import vdt_pkg::*;
#(
  parameter int unsigned RD_W         = 12,
  parameter int unsigned WIN_LO_MV    = 1000,
  parameter int unsigned WIN_HI_MV    = 2000,
  parameter int unsigned PEAK_DROP_MV = 3,
  parameter int unsigned NDV_DROP_MV  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            avg_vld,
  input  logic [RD_W-1:0] avg_mv,
  input  vdt_mode_e       avg_mode,
  input  logic            holdoff,
  output logic            term,
  output logic            done
);

  localparam logic [RD_W-1:0] LO_LIM   = RD_W'(WIN_LO_MV);
  localparam logic [RD_W-1:0] HI_LIM   = RD_W'(WIN_HI_MV);
  localparam logic [RD_W-1:0] PEAK_THR = RD_W'(PEAK_DROP_MV);
  localparam logic [RD_W-1:0] NDV_THR  = RD_W'(NDV_DROP_MV);

  logic            max_vld_q;
  logic [RD_W-1:0] max_q;
  logic            in_win;
  logic            rises;
  logic [RD_W-1:0] drop;
  logic [RD_W-1:0] thr;
  logic            hit;

  assign in_win = (avg_mv > LO_LIM) && (avg_mv < HI_LIM);
  assign rises  = avg_mv > max_q;
  assign drop   = max_q - avg_mv;
  assign thr    = (avg_mode == MODE_NDV) ? NDV_THR : PEAK_THR;
  assign hit    = max_vld_q && !rises && (drop >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_vld_q <= 1'b0;
      max_q     <= '0;
      term      <= 1'b0;
      done      <= 1'b0;
    end else if (clr) begin
      max_vld_q <= 1'b0;
      max_q     <= '0;
      term      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= avg_vld;
      if (avg_vld && in_win) begin
        if (!max_vld_q) begin
          max_vld_q <= 1'b1;
          max_q     <= avg_mv;
        end else if (rises) begin
          max_q <= avg_mv;
        end else if (hit && !holdoff) begin
          term <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vdrop_term.sv
module vdrop_term
  import vdt_pkg::*;
#(
  parameter int unsigned RD_W         = 12,
  parameter int unsigned PEAK_LOG2    = 5,
  parameter int unsigned NDV_LOG2     = 4,
  parameter int unsigned WIN_LO_MV    = 1000,
  parameter int unsigned WIN_HI_MV    = 2000,
  parameter int unsigned PEAK_DROP_MV = 3,
  parameter int unsigned NDV_DROP_MV  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_start,
  input  logic            mode_sel,
  input  logic            holdoff,
  input  logic            hist_clr,
  input  logic            rd_valid,
  output logic            rd_ready,
  input  logic [RD_W-1:0] rd_mv,
  output logic            term,
  output logic            eval_done
);

  logic            take;
  logic            take_last;
  vdt_mode_e       mode_q;
  vdt_mode_e       mode_in;
  logic            avg_vld;
  logic [RD_W-1:0] avg_mv;
  vdt_mode_e       avg_mode;

  assign mode_in = mode_sel ? MODE_NDV : MODE_PEAK;

  vdt_burst_seq #(
    .PEAK_LOG2(PEAK_LOG2),
    .NDV_LOG2 (NDV_LOG2)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (smp_start),
    .clr      (hist_clr),
    .mode_in  (mode_in),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .take     (take),
    .take_last(take_last),
    .mode_q   (mode_q)
  );

  vdt_accum #(
    .RD_W     (RD_W),
    .PEAK_LOG2(PEAK_LOG2),
    .NDV_LOG2 (NDV_LOG2)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (hist_clr),
    .take     (take),
    .take_last(take_last),
    .mode_q   (mode_q),
    .rd_mv    (rd_mv),
    .avg_vld  (avg_vld),
    .avg_mv   (avg_mv),
    .avg_mode (avg_mode)
  );

  vdt_drop_eval #(
    .RD_W        (RD_W),
    .WIN_LO_MV   (WIN_LO_MV),
    .WIN_HI_MV   (WIN_HI_MV),
    .PEAK_DROP_MV(PEAK_DROP_MV),
    .NDV_DROP_MV (NDV_DROP_MV)
  ) u_eval (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (hist_clr),
    .avg_vld (avg_vld),
    .avg_mv  (avg_mv),
    .avg_mode(avg_mode),
    .holdoff (holdoff),
    .term    (term),
    .done    (eval_done)
  );

endmodule

// File: rtl/vdrop_term_chk.sv
module vdrop_term_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_start,
  input logic hist_clr,
  input logic holdoff,
  input logic rd_ready,
  input logic term,
  input logic eval_done
);

  // R2: a burst only opens after a strobe that was not overridden by a clear
  p_ready_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_ready) |-> ($past(smp_start) && !$past(hist_clr)));

  // R5: the completion flag is a single-cycle pulse
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eval_done |=> !eval_done);

  // R10: a new terminate comes with an evaluation made while hold-off was low
  p_hold_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term) |-> (eval_done && !$past(holdoff)));

  // R11: terminate stays high until a clear
  p_term_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !hist_clr) |=> term);

  // R12: a clear closes the burst, drops terminate, and suppresses the pulse
  p_clr_wipes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clr |=> (!rd_ready && !term && !eval_done));

endmodule

bind vdrop_term vdrop_term_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_start(smp_start),
  .hist_clr (hist_clr),
  .holdoff  (holdoff),
  .rd_ready (rd_ready),
  .term     (term),
  .eval_done(eval_done)
);

// File: tb/vdrop_term_tb_top.sv
module vdrop_term_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_start = 1'b0;
  logic        mode_sel = 1'b0;
  logic        holdoff = 1'b0;
  logic        hist_clr = 1'b0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [11:0] rd_mv = '0;
  logic        term;
  logic        eval_done;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  logic got_done, got_term, done_after, ready_after, ready_mid;

  always #2 clk = ~clk;

  vdrop_term dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_start(smp_start),
    .mode_sel (mode_sel),
    .holdoff  (holdoff),
    .hist_clr (hist_clr),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_mv    (rd_mv),
    .term     (term),
    .eval_done(eval_done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      n_errors = n_errors + 1;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, 50000);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks = n_checks + 1;
    if (act != exp) begin
      n_errors = n_errors + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // One burst: n_alt readings of alt, the rest base. Optional valid gap and
  // a stray strobe in the middle of the burst.
  task automatic burst(input logic mode, input int base, input int alt,
                       input int n_alt, input bit gaps);
    int len;
    len = mode ? 16 : 32;
    @(negedge clk);
    mode_sel  = mode;
    smp_start = 1'b1;
    @(negedge clk);
    smp_start = 1'b0;
    ready_mid = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (i == 16) ready_mid = rd_ready;
      if (gaps && i == 3) begin
        rd_valid = 1'b0;
        smp_start = 1'b1;
        @(negedge clk);
        smp_start = 1'b0;
        @(negedge clk);
      end
      rd_valid = 1'b1;
      rd_mv    = 12'((i < n_alt) ? alt : base);
      @(negedge clk);
    end
    rd_valid    = 1'b0;
    ready_after = rd_ready;
    @(negedge clk);
    got_done = eval_done;
    got_term = term;
    @(negedge clk);
    done_after = eval_done;
  endtask

  task automatic sample(input logic mode, input int mv);
    burst(mode, mv, mv, 0, 1'b0);
  endtask

  task automatic clear_hist();
    @(negedge clk);
    hist_clr = 1'b1;
    @(negedge clk);
    hist_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 term after reset", term, 0);
    check("R1 eval_done after reset", eval_done, 0);
    check("R1 rd_ready after reset", rd_ready, 0);
  endtask

  task automatic t_length();
    clear_hist();
    sample(1'b0, 1500);
    check("R3 mode0 ready after 16", ready_mid, 1);
    check("R3 mode0 ready after 32", ready_after, 0);
    check("R5 done pulse", got_done, 1);
    check("R5 done falls", done_after, 0);
    check("R7 first sample no term", got_term, 0);
    sample(1'b1, 1500);
    check("R3 mode1 ready after 16", ready_after, 0);
    check("R5 done mode1", got_done, 1);
  endtask

  task automatic t_start_ignored();
    clear_hist();
    burst(1'b1, 1500, 1500, 0, 1'b1);
    check("R2 stray strobe keeps length", ready_after, 0);
    check("R2 done after gapped burst", got_done, 1);
    @(negedge clk);
    check("R2 no reopen from stray strobe", rd_ready, 0);
  endtask

  task automatic t_peak();
    clear_hist();
    sample(1'b0, 1500);
    sample(1'b0, 1498);
    check("R8 drop 2 no term", got_term, 0);
    sample(1'b0, 1497);
    check("R8 drop 3 term", got_term, 1);
  endtask

  task automatic t_ndv();
    clear_hist();
    sample(1'b1, 1600);
    sample(1'b1, 1589);
    check("R9 drop 11 no term", got_term, 0);
    sample(1'b1, 1620);
    sample(1'b1, 1609);
    check("R11 max raised, drop 11 no term", got_term, 0);
    sample(1'b1, 1608);
    check("R9 drop 12 term", got_term, 1);
  endtask

  task automatic t_avg();
    clear_hist();
    sample(1'b1, 1500);
    burst(1'b1, 1500, 1420, 1, 1'b0);
    check("R4 outlier averaged out", got_term, 0);
    burst(1'b1, 1489, 1488, 8, 1'b0);
    check("R4 floor of mean 1488 term", got_term, 1);
    clear_hist();
    sample(1'b0, 1500);
    burst(1'b0, 1498, 1497, 16, 1'b0);
    check("R4 mode0 floor 1497 term", got_term, 1);
  endtask

  task automatic t_window();
    clear_hist();
    sample(1'b1, 2000);
    check("R6 out of window still done", got_done, 1);
    sample(1'b1, 1500);
    check("R6 2000 did not init, no term", got_term, 0);
    sample(1'b1, 2100);
    sample(1'b1, 1495);
    check("R6 2100 ignored", got_term, 0);
    sample(1'b1, 1000);
    check("R6 1000 no term", got_term, 0);
    sample(1'b1, 900);
    check("R6 900 no term", got_term, 0);
    sample(1'b1, 1488);
    check("R6 in window drop 12 term", got_term, 1);
  endtask

  task automatic t_holdoff();
    clear_hist();
    sample(1'b0, 1500);
    @(negedge clk);
    holdoff = 1'b1;
    sample(1'b0, 1490);
    check("R10 held drop no term", got_term, 0);
    sample(1'b0, 1520);
    @(negedge clk);
    holdoff = 1'b0;
    sample(1'b0, 1517);
    check("R10 max tracked under hold", got_term, 1);
  endtask

  task automatic t_sticky();
    sample(1'b0, 1530);
    check("R11 term sticky", got_term, 1);
    clear_hist();
    check("R12 clear drops term", term, 0);
    sample(1'b0, 1400);
    check("R12 history forgotten", got_term, 0);
  endtask

  task automatic t_clr_abort();
    clear_hist();
    sample(1'b1, 1500);
    @(negedge clk);
    mode_sel  = 1'b0;
    smp_start = 1'b1;
    @(negedge clk);
    smp_start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      rd_valid = 1'b1;
      rd_mv    = 12'd1300;
      @(negedge clk);
    end
    rd_valid = 1'b0;
    hist_clr = 1'b1;
    @(negedge clk);
    hist_clr = 1'b0;
    check("R12 clear closes burst", rd_ready, 0);
    for (int i = 0; i < 4; i++) begin
      check("R12 no done for aborted burst", eval_done, 0);
      @(negedge clk);
    end
    sample(1'b1, 1488);
    check("R12 first after clear only inits", got_term, 0);
    check("R12 new burst completes", got_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_length();
    t_start_ignored();
    t_peak();
    t_ndv();
    t_avg();
    t_window();
    t_holdoff();
    t_sticky();
    t_clr_abort();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 term after second reset", term, 0);
    rst_n = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule